// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. A client hands it one command at a time on a parallel interface: a command code, a word address, write data, a word count and an organization select. The controller then drives chip select, a divided shift clock and serial data toward the memory, and samples the memory's serial output. It builds the instruction frame for the selected organization: a start bit and a two-bit opcode, followed by the address field and, for the two data-carrying commands, the data field.

Read data comes back one word at a time with a valid strobe. The leading dummy zero that the memory sends before the first word is dropped. Several consecutive words can be streamed under one chip-select window. After any programming command the controller lowers chip select for a minimum gap, raises it again and polls the memory's output until it reports ready or a cycle limit runs out. Every command ends with chip select held low for the same minimum gap and a one-cycle done pulse.

Top module: `ser_eeprom_host`

## Requirements
- R1: Every frame starts with a 1, then two opcode bits (read 10, write 01, erase 11, special group 00), then the address field MSB first. Command codes on `cmd_i` are: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 program-enable, 6 program-disable. `sk_o` is low whenever `cs_o` is low, and `di_o` never changes while `sk_o` is high.
- R2: With `org16_i`=0 the address field is 9 bits wide (`addr_i[8:0]`) and data words are 8 bits. With `org16_i`=1 the field is 8 bits wide (`addr_i[7:0]`, and `addr_i[8]` has no effect) and words are 16 bits.
- R3: Special-group commands put a two-bit subcode in the top two address-field bits and zeros in the rest: program-enable 11, erase-all 10, write-all 01, program-disable 00.
- R4: Write and write-all append the data field directly after the address field, MSB first: `wdata_i[7:0]` in 8-bit mode, `wdata_i[15:0]` in 16-bit mode. No other command sends data bits.
- R5: On a read, the bit the memory returns right after the address is discarded. Each following word is shifted in MSB first and presented on `rdata_o` with a one-cycle `rvalid_o`. In 8-bit mode `rdata_o[15:8]` is zero.
- R6: A read returns `nwords_i` words from consecutive addresses (wrapping at the top of the address field) inside one chip-select window, with no dummy bit between words. A count of 0 returns one word.
- R7: The shift clock period is 2*CLK_DIV system clock cycles.
- R8: After write, erase, erase-all or write-all, `cs_o` is held low for at least CS_LOW_CYC cycles and then raised. The controller samples `do_i` until it reads 1, then ends the command with `err_o`=0.
- R9: If `do_i` stays 0 for POLL_MAX poll cycles, the command ends with `err_o`=1. `err_o` is cleared when the next valid command is accepted.
- R10: `start_i` is ignored while a command is in progress.
- R11: `done_o` pulses for exactly one cycle at the end of every command, after `cs_o` has been low for at least CS_LOW_CYC cycles.
- R12: Command code 7 causes no chip-select activity and ends with `done_o` and `err_o`=1.
- R13: During and after reset, `cs_o`, `sk_o`, `di_o`, `done_o`, `rvalid_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, accepted only when idle |
| cmd_i | input | 3 | Command code |
| org16_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| nwords_i | input | CNT_W | Number of words for a read |
| rdata_o | output | DATA_W | Received word |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| done_o | output | 1 | One-cycle end-of-command pulse |
| err_o | output | 1 | Poll timeout or invalid command |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Shift clock to the memory |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data from the memory |

## Verification
The assertions check properties that hold on every cycle: the shift clock stays low whenever chip select is low, serial data holds steady while the clock is high, done lasts one cycle with chip select low, read strobes appear only during reads, and the latched command stays frozen while the controller is busy. Only the bench's scenarios, which use a behavioural memory model, can show that the frame has the right bits in both organizations, that the dummy bit is dropped, and that multi-word reads wrap correctly. The same applies to the poll outcomes, both ready and timeout, and to the measured clock period and chip-select gaps.

// File: rtl/eep_host_pkg.sv
`timescale 1ns/1ps
package eep_host_pkg;
  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_ERAL  = 3'd3,
    CMD_WRAL  = 3'd4,
    CMD_EWEN  = 3'd5,
    CMD_EWDS  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_GAP, S_POLL, S_TAIL
  } state_e;

  function automatic logic is_prog(input logic [2:0] c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
  endfunction
endpackage

// File: rtl/eep_sk_gen.sv
`timescale 1ns/1ps
module eep_sk_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sk_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(DIV-1));
  assign rise_o = wrap && !sk_q;
  assign fall_o = wrap && sk_q;
  assign sk_o   = sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sk_q  <= ~sk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: clock level holds between divider wraps
  p_sk_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap) |=> $stable(sk_q));
endmodule

// File: rtl/eep_frame_build.sv
`timescale 1ns/1ps
module eep_frame_build
  import eep_host_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 2 + ADDR_W + DATA_W,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [2:0]         cmd_i,
  input  logic               org16_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   nbits_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [1:0] opc, sub;
  logic       special, has_data;

  always_comb begin
    opc = 2'b00; sub = 2'b00; special = 1'b0; has_data = 1'b0;
    case (cmd_i)
      CMD_READ:  opc = 2'b10;
      CMD_WRITE: begin opc = 2'b01; has_data = 1'b1; end
      CMD_ERASE: opc = 2'b11;
      CMD_ERAL:  begin special = 1'b1; sub = 2'b10; end
      CMD_WRAL:  begin special = 1'b1; sub = 2'b01; has_data = 1'b1; end
      CMD_EWEN:  begin special = 1'b1; sub = 2'b11; end
      default:   begin special = 1'b1; sub = 2'b00; end
    endcase
  end

  logic [ADDR_W-1:0]  af8;
  logic [ADDR_W-2:0]  af16;
  logic [FRAME_W-1:0] f8, f16;

  assign af8  = special ? {sub, {(ADDR_W-2){1'b0}}} : addr_i;
  assign af16 = special ? {sub, {(ADDR_W-3){1'b0}}} : addr_i[ADDR_W-2:0];

  // frames are left aligned: start bit in the MSB
  assign f16 = {1'b1, opc, af16, has_data ? wdata_i : {DATA_W{1'b0}}};
  assign f8  = {1'b1, opc, af8, has_data ? wdata_i[HALF_W-1:0] : {HALF_W{1'b0}},
                {(HALF_W-1){1'b0}}};

  assign frame_o = org16_i ? f16 : f8;
  assign nbits_o = LEN_W'(3 + (org16_i ? ADDR_W-1 : ADDR_W)
                          + (has_data ? (org16_i ? DATA_W : HALF_W) : 0));
endmodule

// File: rtl/ser_eeprom_host.sv
`timescale 1ns/1ps
module ser_eeprom_host
  import eep_host_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int CLK_DIV    = 4,
  parameter int CS_LOW_CYC = 8,
  parameter int POLL_MAX   = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        cmd_i,
  input  logic              org16_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  nwords_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int FRAME_W = 2 + ADDR_W + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int HALF_W  = DATA_W / 2;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int GAP_W   = $clog2(CS_LOW_CYC + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);

  state_e             state_q;
  logic [2:0]         cmd_q;
  logic               org_q;
  logic [FRAME_W-1:0] tx_q, frame;
  logic [LEN_W-1:0]   tx_left_q, nbits;
  logic [BIT_W-1:0]   bit_q;
  logic [CNT_W-1:0]   words_q;
  logic [DATA_W-2:0]  rx_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q, done_q, err_q, cs_q;
  logic [GAP_W-1:0]   gap_q;
  logic [POLL_W-1:0]  poll_q;
  logic               sk_rise, sk_fall, last_bit;

  eep_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W))
  u_frame (
    .cmd_i(cmd_i), .org16_i(org16_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .frame_o(frame), .nbits_o(nbits)
  );

  eep_sk_gen #(.DIV(CLK_DIV)) u_sk (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(state_q == S_SHIFT),
    .sk_o(sk_o), .rise_o(sk_rise), .fall_o(sk_fall)
  );

  assign last_bit = bit_q == (org_q ? BIT_W'(DATA_W-1) : BIT_W'(HALF_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cmd_q     <= '0;
      org_q     <= 1'b0;
      tx_q      <= '0;
      tx_left_q <= '0;
      bit_q     <= '0;
      words_q   <= '0;
      rx_q      <= '0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      cs_q      <= 1'b0;
      gap_q     <= '0;
      poll_q    <= '0;
    end else begin
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          cmd_q   <= cmd_i;
          org_q   <= org16_i;
          err_q   <= 1'b0;
          words_q <= (nwords_i == '0) ? CNT_W'(1) : nwords_i;
          bit_q   <= '0;
          rx_q    <= '0;
          gap_q   <= '0;
          poll_q  <= '0;
          if (cmd_i > 3'(CMD_EWDS)) begin
            err_q   <= 1'b1;
            state_q <= S_TAIL;
          end else begin
            tx_q      <= frame;
            tx_left_q <= nbits;
            cs_q      <= 1'b1;
            state_q   <= S_SHIFT;
          end
        end
        S_SHIFT: if (sk_fall) begin
          tx_q <= tx_q << 1;
          if (tx_left_q != '0) tx_left_q <= tx_left_q - 1'b1;
          if (tx_left_q == LEN_W'(1) && cmd_q != CMD_READ) begin
            cs_q    <= 1'b0;
            state_q <= is_prog(cmd_q) ? S_GAP : S_TAIL;
          end else if (tx_left_q == '0) begin
            // tx_left_q == 1 on a read is the dummy bit: nothing captured
            rx_q <= {rx_q[DATA_W-3:0], do_i};
            if (last_bit) begin
              rdata_q  <= {rx_q, do_i};
              rvalid_q <= 1'b1;
              rx_q     <= '0;
              bit_q    <= '0;
              words_q  <= words_q - 1'b1;
              if (words_q == CNT_W'(1)) begin
                cs_q    <= 1'b0;
                state_q <= S_TAIL;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        S_GAP: if (gap_q == GAP_W'(CS_LOW_CYC-1)) begin
          gap_q   <= '0;
          cs_q    <= 1'b1;
          state_q <= S_POLL;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
        S_POLL: if (do_i) begin
          cs_q    <= 1'b0;
          state_q <= S_TAIL;
        end else if (poll_q == POLL_W'(POLL_MAX-1)) begin
          err_q   <= 1'b1;
          cs_q    <= 1'b0;
          state_q <= S_TAIL;
        end else begin
          poll_q <= poll_q + 1'b1;
        end
        S_TAIL: if (gap_q == GAP_W'(CS_LOW_CYC-1)) begin
          gap_q   <= '0;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs_o     = cs_q;
  assign di_o     = cs_q & tx_q[FRAME_W-1];
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  p_sk_low_when_deselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sk_o);
  p_di_steady_sk_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));
  p_rvalid_only_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (cmd_q == CMD_READ));
  p_err_cleared_on_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && cmd_i <= 3'(CMD_EWDS)) |=> !err_o);
  p_cmd_frozen_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> ($stable(cmd_q) && $stable(org_q)));
  p_done_one_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_deselected_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);
endmodule

// File: tb/ser_eeprom_host_test.sv
`timescale 1ns/1ps
module ser_eeprom_host_test;
  localparam int ADDR_W = 9, DATA_W = 16, CNT_W = 8;
  localparam int CLK_DIV = 3, CS_LOW = 4, POLL_MAX = 40;
  localparam int TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, org = 1'b0;
  logic [2:0] cmd = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [CNT_W-1:0] nwords = '0;
  logic [DATA_W-1:0] rdata;
  logic rvalid, done, err, cs, sk, di, dout;

  always #(TCLK/2) clk = ~clk;

  ser_eeprom_host #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CLK_DIV(CLK_DIV),
                    .CS_LOW_CYC(CS_LOW), .POLL_MAX(POLL_MAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .org16_i(org),
    .addr_i(addr), .wdata_i(wdata), .nwords_i(nwords), .rdata_o(rdata), .rvalid_o(rvalid),
    .done_o(done), .err_o(err), .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(dout));

  int n_chk = 0, n_fail = 0;

  // ---------------- memory model ----------------
  bit tb_org = 1'b0;
  logic [63:0] cap = '0;
  int ncap = 0, rd_on = 0, rd_bit = 0, cs_rises = 0, sk_rises = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic dev_do = 1'b0, poll_ph = 1'b0;
  int poll_cnt = 0, ready_after = 3;
  time t_fall = 0, min_low = 0, sk_t1 = 0, sk_t2 = 0;

  function automatic logic [15:0] dev_word(input logic [ADDR_W-1:0] a);
    return 16'h3C5A ^ {a[7:0], ~a[7:0]} ^ {7'd0, a};
  endfunction

  function automatic bit prog_frame();
    logic [63:0] h3, s2;
    if (ncap < 5) return 1'b0;
    h3 = (cap >> (ncap - 3)) & 64'd7;
    s2 = (cap >> (ncap - 5)) & 64'd3;
    return (h3 == 64'd5) || (h3 == 64'd7) || (h3 == 64'd4 && (s2 == 64'd2 || s2 == 64'd1));
  endfunction

  always @(posedge sk) if (cs) begin
    int af, w;
    logic [15:0] v;
    af = tb_org ? ADDR_W-1 : ADDR_W;
    w  = tb_org ? 16 : 8;
    cap = {cap[62:0], di};
    ncap++;
    if (sk_rises == 0) sk_t1 = $time;
    else if (sk_rises == 1) sk_t2 = $time;
    sk_rises++;
    if (rd_on != 0) begin
      v = dev_word(rd_addr) & (tb_org ? 16'hFFFF : 16'h00FF);
      dev_do = v[rd_bit];
      if (rd_bit == 0) begin
        rd_bit = w - 1;
        rd_addr = (rd_addr + 1'b1) & ADDR_W'((1 << af) - 1);
      end else rd_bit--;
    end else if (ncap == 3 + af && ((cap >> af) & 64'd7) == 64'd6) begin
      rd_on = 1;
      rd_addr = ADDR_W'(cap & ((64'd1 << af) - 1));
      rd_bit = w - 1;
      dev_do = 1'b0;
    end
  end

  always @(posedge cs) begin
    time lw;
    cs_rises++;
    lw = $time - t_fall;
    if (lw < min_low) min_low = lw;
    if (!poll_ph) begin cap = '0; ncap = 0; rd_on = 0; dev_do = 1'b0; end
  end

  always @(negedge cs) begin
    t_fall = $time;
    rd_on = 0;
    if (poll_ph) poll_ph = 1'b0;
    else if (prog_frame()) poll_ph = 1'b1;
  end

  always @(posedge clk) poll_cnt <= (poll_ph && cs) ? poll_cnt + 1 : 0;

  assign dout = cs ? (poll_ph ? (poll_cnt >= ready_after) : dev_do) : 1'b0;

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void exp_frame(input int c, input bit o, input logic [ADDR_W-1:0] a,
                                    input logic [15:0] wd, output logic [63:0] f, output int len);
    int af, w;
    logic [1:0] op, sub;
    bit spec, dat;
    af = o ? 8 : 9; w = o ? 16 : 8;
    op = 2'b00; sub = 2'b00; spec = 0; dat = 0;
    case (c)
      0: op = 2'b10;
      1: begin op = 2'b01; dat = 1; end
      2: op = 2'b11;
      3: begin spec = 1; sub = 2'b10; end
      4: begin spec = 1; sub = 2'b01; dat = 1; end
      5: begin spec = 1; sub = 2'b11; end
      default: begin spec = 1; sub = 2'b00; end
    endcase
    f = {61'd0, 1'b1, op};
    len = 3;
    for (int i = af - 1; i >= 0; i--) begin
      bit b;
      b = spec ? ((i == af - 1) ? sub[1] : (i == af - 2) ? sub[0] : 1'b0) : a[i];
      f = {f[62:0], b};
      len++;
    end
    if (dat) for (int i = w - 1; i >= 0; i--) begin
      f = {f[62:0], wd[i]};
      len++;
    end
  endfunction

  logic [15:0] got [0:7];
  int got_n = 0;
  bit done_seen = 0, last_err = 0, done_after = 0;
  time done_time = 0;

  task automatic wait_done();
    done_seen = 0;
    for (int i = 0; i < 8000 && !done_seen; i++) begin
      @(negedge clk);
      if (rvalid && got_n < 8) begin got[got_n] = rdata; got_n++; end
      if (done) begin done_seen = 1; last_err = err; done_time = $time; end
    end
    @(negedge clk);
    done_after = done;
  endtask

  task automatic issue(input int c, input bit o, input logic [ADDR_W-1:0] a,
                       input logic [15:0] wd, input int n);
    tb_org = o; cs_rises = 0; sk_rises = 0; got_n = 0; min_low = 64'd1 << 40;
    @(negedge clk);
    cmd = 3'(c); org = o; addr = a; wdata = wd; nwords = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_cmd(input int c, input bit o, input logic [ADDR_W-1:0] a,
                         input logic [15:0] wd, input int n);
    issue(c, o, a, wd, n);
    wait_done();
  endtask

  task automatic chk_frame(input string req, input int c, input bit o,
                           input logic [ADDR_W-1:0] a, input logic [15:0] wd, input int extra);
    logic [63:0] f;
    int len;
    exp_frame(c, o, a, wd, f, len);
    chk({req, " bit count"}, 64'(ncap), 64'(len + extra));
    chk({req, " frame bits"}, (cap >> extra) & ((64'd1 << len) - 1), f);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R13 outputs at reset", {58'd0, cs, sk, di, done, rvalid, err}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 outputs after reset", {58'd0, cs, sk, di, done, rvalid, err}, 64'd0);
  endtask

  task automatic t_enable_x8();
    run_cmd(5, 1'b0, 9'h1FF, 16'hFFFF, 1);
    chk("R11 done seen", 64'(done_seen), 64'd1);
    chk_frame("R3 R2 enable x8", 5, 1'b0, 9'h1FF, 16'hFFFF, 0);
    chk("R11 done one cycle", 64'(done_after), 64'd0);
    chk("R7 shift clock period", 64'(sk_t2 - sk_t1), 64'(2 * CLK_DIV * TCLK));
    chk("R11 cs low before done", 64'(done_time - t_fall >= CS_LOW * TCLK), 64'd1);
  endtask

  task automatic t_disable_x16();
    run_cmd(6, 1'b1, 9'h0AA, 16'h0, 1);
    chk_frame("R3 R2 disable x16", 6, 1'b1, 9'h0AA, 16'h0, 0);
    chk("R8 non-program single window", 64'(cs_rises), 64'd1);
  endtask

  task automatic t_write_x8();
    ready_after = 5;
    run_cmd(1, 1'b0, 9'h1A5, 16'hFF3C, 1);
    chk_frame("R4 R1 write x8", 1, 1'b0, 9'h1A5, 16'hFF3C, 0);
    chk("R8 poll window opened", 64'(cs_rises), 64'd2);
    chk("R8 cs low gap", 64'(min_low >= CS_LOW * TCLK), 64'd1);
    chk("R8 ready no error", 64'(last_err), 64'd0);
  endtask

  task automatic t_write_x16();
    ready_after = 2;
    run_cmd(1, 1'b1, 9'h1AB, 16'hBEEF, 1);
    chk_frame("R4 R2 write x16 high address bit ignored", 1, 1'b1, 9'h0AB, 16'hBEEF, 0);
    chk("R8 write x16 ok", 64'(last_err), 64'd0);
  endtask

  task automatic t_erase_group();
    ready_after = 3;
    run_cmd(2, 1'b0, 9'h0F3, 16'h0, 1);
    chk_frame("R1 erase opcode", 2, 1'b0, 9'h0F3, 16'h0, 0);
    chk("R8 erase polled", 64'(cs_rises), 64'd2);
    run_cmd(3, 1'b1, 9'h055, 16'h1234, 1);
    chk_frame("R3 erase-all x16", 3, 1'b1, 9'h055, 16'h1234, 0);
    chk("R8 erase-all polled", 64'(cs_rises), 64'd2);
    run_cmd(4, 1'b0, 9'h133, 16'h995A, 1);
    chk_frame("R3 R4 write-all x8", 4, 1'b0, 9'h133, 16'h995A, 0);
    chk("R8 write-all ok", 64'(last_err), 64'd0);
  endtask

  task automatic t_read_x16();
    run_cmd(0, 1'b1, 9'h010, 16'h0, 1);
    chk_frame("R5 read x16 frame", 0, 1'b1, 9'h010, 16'h0, 16);
    chk("R5 read x16 words", 64'(got_n), 64'd1);
    chk("R5 read x16 data", 64'(got[0]), 64'(dev_word(9'h010)));
  endtask

  task automatic t_read_seq_x8();
    logic [ADDR_W-1:0] a;
    run_cmd(0, 1'b0, 9'h1FE, 16'h0, 3);
    chk_frame("R6 sequential read frame", 0, 1'b0, 9'h1FE, 16'h0, 24);
    chk("R6 sequential word count", 64'(got_n), 64'd3);
    chk("R6 single cs window", 64'(cs_rises), 64'd1);
    for (int i = 0; i < 3; i++) begin
      a = ADDR_W'(9'h1FE + i);
      chk("R6 R5 sequential x8 word", 64'(got[i]), 64'(dev_word(a) & 16'h00FF));
    end
  endtask

  task automatic t_read_zero_count();
    run_cmd(0, 1'b1, 9'h0C1, 16'h0, 0);
    chk("R6 zero count gives one word", 64'(got_n), 64'd1);
    chk("R6 zero count data", 64'(got[0]), 64'(dev_word(9'h0C1)));
  endtask

  task automatic t_timeout();
    ready_after = 1000000;
    run_cmd(1, 1'b1, 9'h002, 16'h0F0F, 1);
    chk("R9 timeout done", 64'(done_seen), 64'd1);
    chk("R9 timeout error", 64'(last_err), 64'd1);
    ready_after = 2;
    run_cmd(5, 1'b0, 9'h0, 16'h0, 1);
    chk("R9 error cleared by next command", 64'(last_err), 64'd0);
  endtask

  task automatic t_busy_ignore();
    bit cs_seen;
    issue(5, 1'b0, 9'h0, 16'h0, 1);
    repeat (4) @(negedge clk);
    cmd = 3'd0; org = 1'b1; addr = 9'h077; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk_frame("R10 start ignored while busy", 5, 1'b0, 9'h0, 16'h0, 0);
    chk("R10 no read data", 64'(got_n), 64'd0);
    cs_seen = 0;
    repeat (40) begin @(negedge clk); if (cs || done) cs_seen = 1; end
    chk("R10 no second command", 64'(cs_seen), 64'd0);
  endtask

  task automatic t_invalid();
    run_cmd(7, 1'b0, 9'h0, 16'h0, 1);
    chk("R12 invalid done", 64'(done_seen), 64'd1);
    chk("R12 invalid error", 64'(last_err), 64'd1);
    chk("R12 no cs activity", 64'(cs_rises), 64'd0);
  endtask

  initial begin
    t_reset();
    t_enable_x8();
    t_disable_x16();
    t_write_x8();
    t_write_x16();
    t_erase_group();
    t_read_x16();
    t_read_seq_x8();
    t_read_zero_count();
    t_timeout();
    t_busy_ignore();
    t_invalid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule